// File: doc/BRIEF.md
# Interrupt Pending and Arbitration Unit

This block holds the pending and enable bit vectors for a hart's interrupt sources. It also holds a 64-bit timer compare value, and it picks the single interrupt the hart should take next. Software reaches the pending and enable vectors through four views. Two are machine views that show every bit. Two are supervisor views that show only the supervisor soft and supervisor timer bits. Each view has its own writable mask. A real-time counter input is compared against the stored compare value and raises the machine timer pending bit. An inter-processor interrupt pulse sets the machine soft pending bit.

Each cycle the arbiter combines the enabled pending bits with the hart's current privilege, its global interrupt enable and a host message word. From these it decides whether a machine-level or a supervisor-level interrupt may be taken. The host message source counts as pending whenever that word is nonzero. The decision is registered once and appears as a request flag, a level flag and a cause code. Trap entry itself and the source of the time count are outside this block.

Top module: `irq_pend_arb`

## Requirements
- R1: After reset the request output is low, the pending and enable vectors read as zero, and the timer compare value is all ones.
- R2: A machine write to the pending view (select 0) changes only bits 1, 3 and 5. A machine write to the enable view (select 1) changes only bits 1, 3, 5 and 7. Machine reads return the full vectors, and pending bit 7 shows the timer state.
- R3: A supervisor write to the pending view (select 2) changes only bit 1. A supervisor write to the enable view (select 3) changes only bits 1 and 5. Supervisor reads return the stored vector masked to bits 1 and 5.
- R4: Machine timer pending (bit 7) becomes set on the clock edge after the real-time count is greater than or equal to the compare value, and then stays set. A compare write clears it on the write edge. No register-view write can change it.
- R5: An inter-processor pulse sets machine soft pending (bit 3) on its edge, and it wins over a write in the same cycle that clears that bit.
- R6: Machine-level interrupts are taken only when the privilege (0 user, 1 supervisor, 3 machine) is below machine, or is machine with the global enable set.
- R7: Supervisor-level interrupts are taken only when the privilege is below supervisor, or is supervisor with the global enable set.
- R8: Within the machine level the order is soft (cause 0), then timer (cause 1), then host message (cause 2). The host message is pending when the host word is nonzero and does not depend on any enable bit.
- R9: Machine-level candidates win over supervisor-level ones. Within the supervisor level soft (cause 0) wins over timer (cause 1). The level output is high for a machine-level pick.
- R10: The request, level and cause outputs are registered. They show the state one clock edge later and stay asserted while the condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| gie_i | input | 1 | Global interrupt enable for the current privilege |
| csr_we_i | input | 1 | Write strobe for the selected view |
| csr_sel_i | input | 2 | View select: 0 machine pending, 1 machine enable, 2 supervisor pending, 3 supervisor enable |
| csr_wdata_i | input | XLEN | Write data for the selected view |
| csr_rdata_o | output | XLEN | Read data of the selected view |
| tcmp_we_i | input | 1 | Timer compare write strobe |
| tcmp_wdata_i | input | TIME_W | New timer compare value |
| rtc_i | input | TIME_W | Real-time count |
| ipi_i | input | 1 | Inter-processor interrupt pulse |
| host_word_i | input | HOST_W | Host message word; nonzero means a message is pending |
| irq_req_o | output | 1 | Interrupt request |
| irq_mlevel_o | output | 1 | High when the request is machine level |
| irq_cause_o | output | CAUSE_W | Cause code: 0 soft, 1 timer, 2 host |

## Verification
The embedded properties run on every cycle. They check that a compare write clears the timer bit on the next edge, that the timer bit sets and then stays set once the count reaches the compare value, that supervisor writes leave the machine-only bits alone, that an inter-processor pulse lands, and that every request obeys the privilege gate of its level. Only the bench scenarios can show the priority order among simultaneous sources, the exact masked values read back through each view, the host source ignoring the enable vector, and the one-cycle output latency.

// File: rtl/irq_pkg.sv
package irq_pkg;

   // bit positions inside the pending / enable vectors
   localparam int SSIP_BIT = 1;
   localparam int MSIP_BIT = 3;
   localparam int STIP_BIT = 5;
   localparam int MTIP_BIT = 7;
   localparam int MIN_XLEN = MTIP_BIT + 1;

   // privilege encodings
   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   // register view selects
   localparam logic [1:0] VIEW_MPEND = 2'd0;
   localparam logic [1:0] VIEW_MEN   = 2'd1;
   localparam logic [1:0] VIEW_SPEND = 2'd2;
   localparam logic [1:0] VIEW_SEN   = 2'd3;

   // cause codes
   localparam logic [1:0] CAUSE_SOFT  = 2'd0;
   localparam logic [1:0] CAUSE_TIMER = 2'd1;
   localparam logic [1:0] CAUSE_HOST  = 2'd2;

   typedef struct packed {
      logic       req;
      logic       mlevel;
      logic [1:0] code;
   } pick_t;

endpackage

// File: rtl/irq_tcmp_unit.sv
module irq_tcmp_unit #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_we_i,
   input  logic [TIME_W-1:0] cmp_wdata_i,
   input  logic [TIME_W-1:0] rtc_i,
   output logic              mtip_o
);

   localparam logic [TIME_W-1:0] CMP_RESET = {TIME_W{1'b1}};

   generate
      if (TIME_W < 1) begin : g_bad_time_w
         $error("irq_tcmp_unit: TIME_W must be at least 1");
      end
   endgenerate

   logic [TIME_W-1:0] cmp_q;
   logic              mtip_q;
   logic              reached;

   assign reached = (rtc_i >= cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q  <= CMP_RESET;
         mtip_q <= 1'b0;
      end else if (cmp_we_i) begin
         cmp_q  <= cmp_wdata_i;
         mtip_q <= 1'b0;
      end else if (reached) begin
         mtip_q <= 1'b1;
      end
   end

   assign mtip_o = mtip_q;

   // R4: a compare write clears the timer pending bit
   a_r4_cmp_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_we_i |=> !mtip_o);

   // R4: reaching the compare value sets the bit
   a_r4_reach_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_we_i && (rtc_i >= cmp_q)) |=> mtip_o);

   // R4: the bit stays set until a compare write
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (mtip_o && !cmp_we_i) |=> mtip_o);

endmodule

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [1:0]      sel_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic            ipi_i,
   input  logic            mtip_i,
   output logic [XLEN-1:0] pend_o,
   output logic [XLEN-1:0] en_o,
   output logic [XLEN-1:0] rdata_o
);
   import irq_pkg::*;

   localparam logic [XLEN-1:0] ONE        = {{(XLEN-1){1'b0}}, 1'b1};
   localparam logic [XLEN-1:0] B_SSIP     = ONE << SSIP_BIT;
   localparam logic [XLEN-1:0] B_MSIP     = ONE << MSIP_BIT;
   localparam logic [XLEN-1:0] B_STIP     = ONE << STIP_BIT;
   localparam logic [XLEN-1:0] B_MTIP     = ONE << MTIP_BIT;
   localparam logic [XLEN-1:0] M_PEND_WM  = B_SSIP | B_MSIP | B_STIP;
   localparam logic [XLEN-1:0] M_EN_WM    = B_SSIP | B_MSIP | B_STIP | B_MTIP;
   localparam logic [XLEN-1:0] S_PEND_WM  = B_SSIP;
   localparam logic [XLEN-1:0] S_EN_WM    = B_SSIP | B_STIP;
   localparam logic [XLEN-1:0] S_READ_M   = B_SSIP | B_STIP;

   generate
      if (XLEN < MIN_XLEN) begin : g_bad_xlen
         $error("irq_pend_store: XLEN too narrow for the interrupt bit layout");
      end
   endgenerate

   logic [XLEN-1:0] pend_q, pend_d;
   logic [XLEN-1:0] en_q, en_d;

   function automatic logic [XLEN-1:0] merge(input logic [XLEN-1:0] old_v,
                                             input logic [XLEN-1:0] new_v,
                                             input logic [XLEN-1:0] msk);
      return (old_v & ~msk) | (new_v & msk);
   endfunction

   always_comb begin
      pend_d = pend_q;
      en_d   = en_q;
      if (we_i) begin
         unique case (sel_i)
            VIEW_MPEND: pend_d = merge(pend_q, wdata_i, M_PEND_WM);
            VIEW_MEN:   en_d   = merge(en_q,   wdata_i, M_EN_WM);
            VIEW_SPEND: pend_d = merge(pend_q, wdata_i, S_PEND_WM);
            default:    en_d   = merge(en_q,   wdata_i, S_EN_WM);
         endcase
      end
      if (ipi_i) pend_d = pend_d | B_MSIP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         en_q   <= '0;
      end else begin
         pend_q <= pend_d;
         en_q   <= en_d;
      end
   end

   assign pend_o = (pend_q & ~B_MTIP) | (mtip_i ? B_MTIP : '0);
   assign en_o   = en_q;

   always_comb begin
      unique case (sel_i)
         VIEW_MPEND: rdata_o = pend_o;
         VIEW_MEN:   rdata_o = en_q;
         VIEW_SPEND: rdata_o = pend_o & S_READ_M;
         default:    rdata_o = en_q & S_READ_M;
      endcase
   end

   // R3: supervisor pending write leaves supervisor timer pending alone
   a_r3_sip_keeps_stip: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && sel_i == VIEW_SPEND) |=> $stable(pend_q[STIP_BIT]));

   // R3: supervisor enable write leaves machine enables alone
   a_r3_sie_keeps_m: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && sel_i == VIEW_SEN) |=> ($stable(en_q[MSIP_BIT]) && $stable(en_q[MTIP_BIT])));

   // R5: inter-processor pulse sets machine soft pending
   a_r5_ipi_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_i |=> pend_o[MSIP_BIT]);

   // R2: a machine enable write is observed at the read port
   a_r2_men_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && sel_i == VIEW_MEN) |=> (en_o[MTIP_BIT] == $past(wdata_i[MTIP_BIT])));

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int XLEN = 64
) (
   input  logic             [1:0]      priv_i,
   input  logic                        gie_i,
   input  logic             [XLEN-1:0] pend_i,
   input  logic             [XLEN-1:0] en_i,
   input  logic                        host_nz_i,
   output irq_pkg::pick_t              pick_o
);
   import irq_pkg::*;

   logic [XLEN-1:0] live;
   logic            m_open, s_open;

   assign live   = pend_i & en_i;
   assign m_open = (priv_i < PRIV_M) || ((priv_i == PRIV_M) && gie_i);
   assign s_open = (priv_i < PRIV_S) || ((priv_i == PRIV_S) && gie_i);

   always_comb begin
      pick_o = '0;
      if (m_open && live[MSIP_BIT]) begin
         pick_o = '{req: 1'b1, mlevel: 1'b1, code: CAUSE_SOFT};
      end else if (m_open && live[MTIP_BIT]) begin
         pick_o = '{req: 1'b1, mlevel: 1'b1, code: CAUSE_TIMER};
      end else if (m_open && host_nz_i) begin
         pick_o = '{req: 1'b1, mlevel: 1'b1, code: CAUSE_HOST};
      end else if (s_open && live[SSIP_BIT]) begin
         pick_o = '{req: 1'b1, mlevel: 1'b0, code: CAUSE_SOFT};
      end else if (s_open && live[STIP_BIT]) begin
         pick_o = '{req: 1'b1, mlevel: 1'b0, code: CAUSE_TIMER};
      end
   end

endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
   parameter int XLEN    = 64,
   parameter int TIME_W  = 64,
   parameter int HOST_W  = 64,
   parameter int CAUSE_W = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         priv_i,
   input  logic               gie_i,
   input  logic               csr_we_i,
   input  logic [1:0]         csr_sel_i,
   input  logic [XLEN-1:0]    csr_wdata_i,
   output logic [XLEN-1:0]    csr_rdata_o,
   input  logic               tcmp_we_i,
   input  logic [TIME_W-1:0]  tcmp_wdata_i,
   input  logic [TIME_W-1:0]  rtc_i,
   input  logic               ipi_i,
   input  logic [HOST_W-1:0]  host_word_i,
   output logic               irq_req_o,
   output logic               irq_mlevel_o,
   output logic [CAUSE_W-1:0] irq_cause_o
);
   import irq_pkg::*;

   generate
      if (CAUSE_W < 2) begin : g_bad_cause_w
         $error("irq_pend_arb: CAUSE_W must hold cause code 2");
      end
      if (HOST_W < 1) begin : g_bad_host_w
         $error("irq_pend_arb: HOST_W must be at least 1");
      end
   endgenerate

   logic            mtip;
   logic [XLEN-1:0] pend, en;
   logic            host_nz;
   pick_t           pick;

   assign host_nz = |host_word_i;

   irq_tcmp_unit #(.TIME_W(TIME_W)) u_tcmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmp_we_i    (tcmp_we_i),
      .cmp_wdata_i (tcmp_wdata_i),
      .rtc_i       (rtc_i),
      .mtip_o      (mtip)
   );

   irq_pend_store #(.XLEN(XLEN)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (csr_we_i),
      .sel_i   (csr_sel_i),
      .wdata_i (csr_wdata_i),
      .ipi_i   (ipi_i),
      .mtip_i  (mtip),
      .pend_o  (pend),
      .en_o    (en),
      .rdata_o (csr_rdata_o)
   );

   irq_pick #(.XLEN(XLEN)) u_pick (
      .priv_i    (priv_i),
      .gie_i     (gie_i),
      .pend_i    (pend),
      .en_i      (en),
      .host_nz_i (host_nz),
      .pick_o    (pick)
   );

   generate
      if (OUT_REG) begin : g_out_reg
         pick_t pick_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pick_q <= '0;
            else        pick_q <= pick;
         end
         assign irq_req_o    = pick_q.req;
         assign irq_mlevel_o = pick_q.mlevel;
         assign irq_cause_o  = CAUSE_W'(pick_q.code);

         // R6: machine-level requests respect the machine gate
         a_r6_m_gate: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req_o && irq_mlevel_o) |-> $past((priv_i != PRIV_M) || gie_i));

         // R7: supervisor-level requests respect the supervisor gate
         a_r7_s_gate: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req_o && !irq_mlevel_o) |->
               $past((priv_i < PRIV_S) || ((priv_i == PRIV_S) && gie_i)));
      end else begin : g_out_comb
         assign irq_req_o    = pick.req;
         assign irq_mlevel_o = pick.mlevel;
         assign irq_cause_o  = CAUSE_W'(pick.code);
      end
   endgenerate

   // R8: the host cause only ever appears at machine level
   a_r8_host_is_m: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req_o && irq_cause_o == CAUSE_W'(CAUSE_HOST)) |-> irq_mlevel_o);

   // R9: supervisor-level causes are soft or timer only
   a_r9_s_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req_o && !irq_mlevel_o) |-> (irq_cause_o <= CAUSE_W'(CAUSE_TIMER)));

endmodule

// File: tb/irq_pend_arb_bench.sv
`timescale 1ns/1ps
module irq_pend_arb_bench;

   localparam int XLEN = 64;
   localparam int TW   = 64;
   localparam int HW   = 64;
   localparam int CW   = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      priv_i = 2'd3;
   logic            gie_i = 1'b0;
   logic            csr_we_i = 1'b0;
   logic [1:0]      csr_sel_i = 2'd0;
   logic [XLEN-1:0] csr_wdata_i = '0;
   logic [XLEN-1:0] csr_rdata_o;
   logic            tcmp_we_i = 1'b0;
   logic [TW-1:0]   tcmp_wdata_i = '0;
   logic [TW-1:0]   rtc_i = '0;
   logic            ipi_i = 1'b0;
   logic [HW-1:0]   host_word_i = '0;
   logic            irq_req_o, irq_mlevel_o;
   logic [CW-1:0]   irq_cause_o;

   always #2 clk = ~clk;

   irq_pend_arb #(.XLEN(XLEN), .TIME_W(TW), .HOST_W(HW), .CAUSE_W(CW)) u_irq_pend_arb (
      .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .gie_i(gie_i),
      .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i),
      .csr_rdata_o(csr_rdata_o), .tcmp_we_i(tcmp_we_i), .tcmp_wdata_i(tcmp_wdata_i),
      .rtc_i(rtc_i), .ipi_i(ipi_i), .host_word_i(host_word_i),
      .irq_req_o(irq_req_o), .irq_mlevel_o(irq_mlevel_o), .irq_cause_o(irq_cause_o)
   );

   // scoreboard
   int              n_vec = 0;
   int              n_bad = 0;
   int              kind_q[$];
   logic [63:0]     exp_q[$];
   string           tag_q[$];
   event            chk_ev;

   always begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
         automatic int          k = kind_q.pop_front();
         automatic logic [63:0] e = exp_q.pop_front();
         automatic string       t = tag_q.pop_front();
         automatic logic [63:0] a;
         if (k == 0) a = {60'd0, irq_req_o, irq_mlevel_o, irq_cause_o[1:0]};
         else        a = csr_rdata_o;
         n_vec++;
         if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
         end
      end
   end

   task automatic push(input int k, input logic [63:0] e, input string t);
      kind_q.push_back(k);
      exp_q.push_back(e);
      tag_q.push_back(t);
      -> chk_ev;
      #0.2;
   endtask

   // irq expected code: {req, mlevel, cause[1:0]}
   task automatic chk_irq(input logic [3:0] e, input string t);
      @(negedge clk); #0.2;
      push(0, {60'd0, e}, t);
   endtask

   task automatic chk_now(input logic [3:0] e, input string t);
      #0.2;
      push(0, {60'd0, e}, t);
   endtask

   task automatic rd(input logic [1:0] s, input logic [63:0] e, input string t);
      @(negedge clk);
      csr_sel_i = s;
      #0.2;
      push(1, e, t);
   endtask

   task automatic wr(input logic [1:0] s, input logic [63:0] d, input logic with_ipi);
      @(negedge clk);
      csr_we_i = 1'b1; csr_sel_i = s; csr_wdata_i = d; ipi_i = with_ipi;
      @(posedge clk); #0.2;
      csr_we_i = 1'b0; ipi_i = 1'b0;
   endtask

   task automatic wr_tcmp(input logic [63:0] d);
      @(negedge clk);
      tcmp_we_i = 1'b1; tcmp_wdata_i = d;
      @(posedge clk); #0.2;
      tcmp_we_i = 1'b0;
   endtask

   task automatic pulse_ipi();
      @(negedge clk);
      ipi_i = 1'b1;
      @(posedge clk); #0.2;
      ipi_i = 1'b0;
   endtask

   task automatic set_mode(input logic [1:0] p, input logic g);
      @(negedge clk);
      priv_i = p; gie_i = g;
   endtask

   task automatic tick();
      @(posedge clk); #0.2;
   endtask

   bit done = 1'b0;

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      chk_irq(4'h0, "R1 request after reset");
      rd(2'd0, 64'h0, "R1 pending after reset");
      rd(2'd1, 64'h0, "R1 enable after reset");

      // R2 machine write masks
      wr(2'd1, 64'hFF, 1'b0);
      rd(2'd1, 64'hAA, "R2 machine enable mask");
      wr(2'd0, 64'hFF, 1'b0);
      rd(2'd0, 64'h2A, "R2 machine pending mask");
      tick();
      chk_irq(4'h0, "R6 machine with enable clear");

      set_mode(2'd3, 1'b1);
      chk_irq(4'hC, "R6 machine soft at machine with enable");

      wr(2'd0, 64'h22, 1'b0);
      tick();
      chk_irq(4'h0, "R7 supervisor not taken at machine");

      set_mode(2'd1, 1'b0);
      chk_irq(4'h0, "R7 supervisor with enable clear");
      set_mode(2'd1, 1'b1);
      chk_irq(4'h8, "R9 supervisor soft");
      chk_irq(4'h8, "R10 request held");

      // R3 supervisor views
      wr(2'd2, 64'h00, 1'b0);
      rd(2'd0, 64'h20, "R3 supervisor pending write");
      tick();
      chk_irq(4'h9, "R9 supervisor timer");
      wr(2'd2, 64'hFF, 1'b0);
      rd(2'd0, 64'h22, "R3 supervisor pending sets soft only");
      wr(2'd3, 64'h00, 1'b0);
      rd(2'd1, 64'h88, "R3 supervisor enable mask");
      rd(2'd3, 64'h00, "R3 supervisor enable read");
      tick();
      chk_irq(4'h0, "R7 nothing enabled at supervisor");

      // R8 host source
      host_word_i = 64'd5;
      set_mode(2'd0, 1'b0);
      chk_irq(4'hE, "R8 host message");
      wr(2'd1, 64'h00, 1'b0);
      tick();
      chk_irq(4'hE, "R8 host ignores enable");

      wr(2'd1, 64'hFF, 1'b0);
      wr(2'd0, 64'h08, 1'b0);
      tick();
      chk_irq(4'hC, "R8 soft over host");
      rd(2'd2, 64'h00, "R3 supervisor view hides machine soft");

      // R4 timer
      wr(2'd0, 64'h00, 1'b0);
      rtc_i = 64'd20;
      wr_tcmp(64'd10);
      rd(2'd0, 64'h00, "R4 compare write clears");
      rd(2'd0, 64'h80, "R4 count above compare sets");
      chk_irq(4'hD, "R8 timer over host");
      wr(2'd0, 64'h00, 1'b0);
      rd(2'd0, 64'h80, "R4 view write cannot clear timer");
      host_word_i = '0;
      wr_tcmp(64'd100);
      rd(2'd0, 64'h00, "R4 new compare clears");
      rd(2'd0, 64'h00, "R4 count below compare");
      @(negedge clk); rtc_i = 64'd100;
      rd(2'd0, 64'h80, "R4 count equal compare sets");

      // R5 inter-processor pulse
      pulse_ipi();
      rd(2'd0, 64'h88, "R5 pulse sets soft");
      wr(2'd0, 64'h00, 1'b1);
      rd(2'd0, 64'h88, "R5 pulse wins over clear");

      // R9 machine before supervisor
      wr(2'd0, 64'h22, 1'b0);
      tick();
      chk_irq(4'hD, "R9 machine timer over supervisor soft");
      wr(2'd1, 64'h22, 1'b0);
      tick();
      chk_irq(4'h8, "R9 supervisor soft at user");
      set_mode(2'd3, 1'b1);
      chk_irq(4'h0, "R7 supervisor blocked at machine");

      // R10 latency
      set_mode(2'd0, 1'b0);
      chk_now(4'h0, "R10 old value before edge");
      chk_irq(4'h8, "R10 new value after edge");

      #1;
      -> chk_ev;
      #1;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule